// File: doc/BRIEF.md
# Integer ALU with Shared-Adder Comparison

This block is a purely combinational integer arithmetic and logic unit for an execution stage. It takes two operands in two's complement form, a four-bit operation code, and a 16-bit immediate with a flag that selects it. It returns a result word and three flags: carry, zero and negative. Its width is a parameter, and the default is 32 bits.

One adder serves addition, subtraction and both less-than tests. For subtraction and comparison, the adder forms A plus the inverted B plus one. A less-than decision then combines the two operand top bits with the top bit of that difference, so the block has no separate magnitude comparator.

The logic operations can take the zero-extended immediate in place of B. The shifts take their amount from the low bits of B. The block has no state, so it has no clock, no reset and no states or transitions.

Top module: `alu_core`

## Requirements
- R1: Operation code 0 (add) gives result = A + B modulo 2^W, with carry equal to the carry out of bit W-1.
- R2: Operation code 1 (subtract) gives result = A - B modulo 2^W. Carry is 1 exactly when A >= B as unsigned numbers, which is the carry out of A + ~B + 1.
- R3: Operation code 2 (signed less-than) gives 1 in bit 0 when A < B as two's complement numbers and 0 otherwise. All bits above bit 0 are 0.
- R4: Operation code 3 (unsigned less-than) gives 1 in bit 0 when A < B as unsigned numbers and 0 otherwise. All bits above bit 0 are 0.
- R5: With the immediate flag low, operation codes 4, 5, 6 and 7 give A AND B, A OR B, A XOR B and NOT(A OR B).
- R6: With the immediate flag high, operation codes 4 to 7 use the 16-bit immediate, zero-extended to W bits, in place of B.
- R7: The immediate flag and the immediate value have no effect on any operation code other than 4 to 7.
- R8: Operation codes 8, 9 and 10 shift A left logically, right logically (zero fill) and right arithmetically (sign fill). The shift amount is the low log2(W) bits of B, and the higher bits of B are ignored.
- R9: For operation codes 0 to 10, the zero flag is 1 exactly when the result is all zeros, and the negative flag equals the result's top bit.
- R10: The carry flag is 0 for operation codes 2 to 10.
- R11: Operation codes 11 to 15 give an all-zero result with carry, zero and negative flags all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | W | First operand, two's complement |
| b_in | input | W | Second operand, two's complement; low bits give the shift amount |
| op_sel | input | 4 | Operation code |
| imm_val | input | 16 | Unsigned immediate for logic operations |
| imm_en | input | 1 | Selects the immediate in place of B for logic operations |
| result | output | W | Result word |
| carry_o | output | 1 | Adder carry out for add and subtract |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Copy of the result's top bit |

## Verification
Both less-than codes are driven with fixed corner pairs: equal operands, the most negative value against zero, all-ones against zero, and the largest positive value against the most negative. In these pairs the signed and unsigned answers disagree, or the top bit of the difference misleads, so they show whether the sign-bit terms are combined correctly. Random operands with random codes and immediates then cover every operation. Shift amounts with the upper B bits set show whether those bits are masked. Unused codes and toggled immediate flags on non-logic codes check that nothing leaks into the result or the flags.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_LTS = 4'd2,
        OP_LTU = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_NOR = 4'd7,
        OP_SLL = 4'd8,
        OP_SRL = 4'd9,
        OP_SRA = 4'd10
    } alu_op_e;

    localparam int IMM_W = 16;
    localparam logic [3:0] OP_LAST = 4'd10;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         sub_mode,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] opb_eff;
    logic [W:0]   total;

    // subtract: A + ~B + 1 on the same carry chain
    always_comb begin
        opb_eff = sub_mode ? ~opb : opb;
        total   = {1'b0, opa} + {1'b0, opb_eff} + {{W{1'b0}}, sub_mode};
    end

    assign sum  = total[W-1:0];
    assign cout = total[W];
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_imm,
    input  logic [1:0]       fn,
    output logic [W-1:0]     out
);
    logic [W-1:0] imm_ext;
    logic [W-1:0] rhs;

    generate
        if (W > IMM_W) begin : g_pad
            assign imm_ext = {{(W-IMM_W){1'b0}}, imm};
        end else begin : g_trim
            assign imm_ext = imm[W-1:0];
        end
    endgenerate

    always_comb begin
        rhs = use_imm ? imm_ext : opb;
        case (fn)
            2'd0:    out = opa & rhs;
            2'd1:    out = opa | rhs;
            2'd2:    out = opa ^ rhs;
            default: out = ~(opa | rhs);
        endcase
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   opa,
    input  logic [SHW-1:0] amt,
    input  logic [1:0]     mode,
    output logic [W-1:0]   out
);
    always_comb begin
        case (mode)
            2'd0:    out = opa << amt;
            2'd1:    out = opa >> amt;
            default: out = W'($signed(opa) >>> amt);
        endcase
    end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [3:0]   op_sel,
    input  logic [15:0]  imm_val,
    input  logic         imm_en,
    output logic [W-1:0] result,
    output logic         carry_o,
    output logic         zero_o,
    output logic         neg_o
);
    import alu_pkg::*;

    localparam int SHW = $clog2(W);

    alu_op_e      op;
    logic         sub_mode;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic [W-1:0] logic_out;
    logic [W-1:0] shift_out;
    logic         a_top, b_top, d_top, same_top;
    logic         lt_signed, lt_unsigned;
    logic         op_valid;

    assign op       = alu_op_e'(op_sel);
    assign sub_mode = (op == OP_SUB) || (op == OP_LTS) || (op == OP_LTU);

    alu_adder #(.W(W)) u_add (
        .opa(a_in), .opb(b_in), .sub_mode(sub_mode),
        .sum(add_sum), .cout(add_cout)
    );

    alu_logic #(.W(W), .IMM_W(IMM_W)) u_log (
        .opa(a_in), .opb(b_in), .imm(imm_val), .use_imm(imm_en),
        .fn(op_sel[1:0]), .out(logic_out)
    );

    alu_shift #(.W(W), .SHW(SHW)) u_shf (
        .opa(a_in), .amt(b_in[SHW-1:0]), .mode(op_sel[1:0]),
        .out(shift_out)
    );

    // comparison from operand top bits and the difference top bit
    always_comb begin
        a_top       = a_in[W-1];
        b_top       = b_in[W-1];
        d_top       = add_sum[W-1];
        same_top    = ~(a_top ^ b_top);
        lt_signed   = (a_top & ~b_top) | (same_top & d_top);
        lt_unsigned = (~a_top & b_top) | (same_top & d_top);
    end

    always_comb begin
        result   = '0;
        carry_o  = 1'b0;
        op_valid = 1'b1;
        case (op)
            OP_ADD, OP_SUB: begin
                result  = add_sum;
                carry_o = add_cout;
            end
            OP_LTS:                         result = {{(W-1){1'b0}}, lt_signed};
            OP_LTU:                         result = {{(W-1){1'b0}}, lt_unsigned};
            OP_AND, OP_OR, OP_XOR, OP_NOR:  result = logic_out;
            OP_SLL, OP_SRL, OP_SRA:         result = shift_out;
            default:                        op_valid = 1'b0;
        endcase
    end

    assign zero_o = op_valid & (result == '0);
    assign neg_o  = op_valid & result[W-1];
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [3:0]   op_sel,
    input logic [W-1:0] result,
    input logic         carry_o,
    input logic         zero_o,
    input logic         neg_o
);
    always_comb begin
        if (op_sel <= 4'd10) begin
            p_zero_flag_r9: assert (zero_o == (result == '0));
            p_neg_flag_r9:  assert (neg_o == result[W-1]);
        end
        if (op_sel == 4'd1) begin
            p_sub_carry_r2: assert (carry_o == (a_in >= b_in));
        end
        if (op_sel == 4'd2 || op_sel == 4'd3) begin
            p_lt_upper_r3: assert (result[W-1:1] == '0);
        end
        if (op_sel >= 4'd2) begin
            p_carry_quiet_r10: assert (!carry_o);
        end
        if (op_sel > 4'd10) begin
            p_unused_clear_r11: assert (result == '0 && !zero_o && !neg_o);
        end
    end
endmodule

bind alu_core alu_core_chk #(.W(W)) u_chk (
    .a_in(a_in), .b_in(b_in), .op_sel(op_sel), .result(result),
    .carry_o(carry_o), .zero_o(zero_o), .neg_o(neg_o)
);

// File: tb/tb_alu_core.sv
module tb_alu_core;
    localparam int W = 32;
    localparam time PERIOD = 10;

    logic         clk = 1'b0;
    logic [W-1:0] a_in, b_in;
    logic [3:0]   op_sel;
    logic [15:0]  imm_val;
    logic         imm_en;
    logic [W-1:0] result;
    logic         carry_o, zero_o, neg_o;

    int checks = 0;
    int failures = 0;

    alu_core #(.W(W)) dut (
        .a_in(a_in), .b_in(b_in), .op_sel(op_sel), .imm_val(imm_val),
        .imm_en(imm_en), .result(result), .carry_o(carry_o),
        .zero_o(zero_o), .neg_o(neg_o)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic string tag_of(input logic [3:0] op, input logic ie);
        if (op == 0) return "R1";
        if (op == 1) return "R2";
        if (op == 2) return "R3";
        if (op == 3) return "R4";
        if (op <= 7) return ie ? "R6" : "R5";
        if (op <= 10) return "R8";
        return "R11";
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", tag, op_sel, a_in, b_in, act, exp);
        end
    endtask

    // behavioural model, compared once per clock
    task automatic apply(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [15:0] imm, input logic ie);
        logic [W-1:0] er, rhs;
        logic ec, ez, en;
        longint ua, ub;
        @(negedge clk);
        op_sel = op; a_in = a; b_in = b; imm_val = imm; imm_en = ie;
        ua = longint'(a); ub = longint'(b);
        rhs = ie ? W'(imm) : b;
        ec = 1'b0;
        case (op)
            4'd0: begin er = a + b; ec = (ua + ub) >= 64'sh1_0000_0000; end
            4'd1: begin er = a - b; ec = (ua >= ub); end
            4'd2: er = ($signed(a) < $signed(b)) ? 1 : 0;
            4'd3: er = (ua < ub) ? 1 : 0;
            4'd4: er = a & rhs;
            4'd5: er = a | rhs;
            4'd6: er = a ^ rhs;
            4'd7: er = ~(a | rhs);
            4'd8: er = a << (b % W);
            4'd9: er = a >> (b % W);
            4'd10: er = W'($signed(a) >>> (b % W));
            default: er = '0;
        endcase
        ez = (op <= 10) && (er == 0);
        en = (op <= 10) && er[W-1];
        @(posedge clk);
        #1;
        check(tag_of(op, ie), result, er);
        check((op >= 2) ? "R10" : tag_of(op, ie), W'(carry_o), W'(ec));
        check((op > 10) ? "R11" : "R9", W'({zero_o, neg_o}), W'({ez, en}));
    endtask

    initial begin
        #(PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [W-1:0] corners [6];
        a_in = '0; b_in = '0; op_sel = '0; imm_val = '0; imm_en = 1'b0;
        // initial state: add of zeros (R1, R9)
        apply(4'd0, '0, '0, 16'h0, 1'b0);
        // R1 carry out
        apply(4'd0, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0);
        // R2 borrow and no-borrow
        apply(4'd1, 32'h5, 32'h7, 16'h0, 1'b0);
        apply(4'd1, 32'h7, 32'h7, 16'h0, 1'b0);
        // R3 / R4 corner pairs
        corners[0] = 32'h0;          corners[1] = 32'h8000_0000;
        corners[2] = 32'hFFFF_FFFF;  corners[3] = 32'h7FFF_FFFF;
        corners[4] = 32'h1;          corners[5] = 32'h8000_0001;
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++) begin
                apply(4'd2, corners[i], corners[j], 16'h0, 1'b0);
                apply(4'd3, corners[i], corners[j], 16'h0, 1'b0);
            end
        // R6 immediate zero-extension on all four logic codes
        for (int k = 4; k <= 7; k++)
            apply(4'(k), 32'hF0F0_F0F0, 32'h1234_5678, 16'hFFFF, 1'b1);
        // R7 immediate ignored on non-logic codes
        apply(4'd0, 32'h10, 32'h20, 16'hABCD, 1'b1);
        apply(4'd3, 32'h10, 32'h20, 16'hFFFF, 1'b1);
        apply(4'd10, 32'h8000_0000, 32'h4, 16'h1234, 1'b1);
        // R8 upper bits of B ignored; sign fill vs zero fill
        apply(4'd8, 32'h1, 32'hFFFF_FFE3, 16'h0, 1'b0);
        apply(4'd9, 32'h8000_0000, 32'h0000_0104, 16'h0, 1'b0);
        apply(4'd10, 32'h8000_0000, 32'h0000_011F, 16'h0, 1'b0);
        // R11 unused codes
        for (int k = 11; k < 16; k++)
            apply(4'(k), 32'hFFFF_FFFF, 32'h1, 16'hFFFF, 1'b1);
        // random sweep, including compares (R3, R4, R5, R9, R10)
        for (int n = 0; n < 3000; n++)
            apply(4'($urandom_range(0, 15)), $urandom, $urandom,
                  16'($urandom), 1'($urandom));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule